// File: doc/BRIEF.md
# DDR SDRAM Single-Bank Read Sequencer with Implicit Precharge

This block drives the command and address pins of one DDR SDRAM bank for a single read that closes its row by itself. When a request is accepted it opens the row, waits out the activate-to-read and activate-to-auto-precharge delays, and issues a READ with the auto-precharge address bit set. Every other cycle carries a NOP. The device then precharges the bank on its own. The sequencer models that hidden precharge: the precharge period begins only once the minimum row-active time has run out, counted from the ACTIVE. A second ACTIVE to the bank is refused until that chained interval and the row cycle time have both passed.

The column address is spread over the address pins according to the configured device width. A separate output marks the two clocks in which the four-word burst is returned, counted from the READ by the CAS latency. Delays are parameters in clock cycles. The request is sampled on any clock edge where `busy` is low.

Top module: `sdram_rdap_seq`

## Requirements
- R1: Out of reset the command is NOP, the address and bank pins are zero, `rd_valid` is low and `busy` is low.
- R2: A request sampled while `busy` is low puts ACTIVE ({cs_n,ras_n,cas_n,we_n}=0011) on the pins in the next cycle, with the row on `cmd_addr` and the bank on `cmd_ba`, and `busy` goes high in that same cycle.
- R3: READ (0101) appears exactly max(T_RCD,T_RAP) cycles after the ACTIVE, with `cmd_addr[10]` high to request auto precharge.
- R4: On the READ, column bits 9..0 drive `cmd_addr[9:0]`. Column bit 10 drives `cmd_addr[11]` for widths x4 (`cfg_width`=0) and x8 (1). Column bit 11 drives `cmd_addr[12]` for x4 only. Any unused pin is zero, and codes 2 and 3 both mean x16. The width is taken from the request.
- R5: The READ carries on `cmd_ba` the same bank as its ACTIVE.
- R6: Every cycle that is neither that ACTIVE nor that READ is NOP (0111) with address and bank pins zero.
- R7: `rd_valid` is high for exactly BL/2 = 2 cycles, starting CL = 2 cycles after the READ.
- R8: The precharge interval T_RP starts only after T_RAS has elapsed from the ACTIVE. `busy` falls so that a held request produces the next ACTIVE exactly max(T_RC, T_RAS+T_RP) cycles after the previous one, and never earlier.
- R9: A request presented while `busy` is high has no effect: no command and no captured address results from it.
- R10: R3 and R8 hold for other parameter sets, including one where T_RAP exceeds T_RCD and T_RC exceeds T_RAS+T_RP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release must already be synchronous to clk |
| req_valid | input | 1 | Read request, accepted on an edge where busy is low |
| req_row | input | ADDR_W | Row address |
| req_col | input | COL_W | Column address (logical bits) |
| req_bank | input | BANK_W | Bank address |
| cfg_width | input | 2 | Device width: 0 x4, 1 x8, 2 or 3 x16 |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_addr | output | ADDR_W | Address pins A0 upward |
| cmd_ba | output | BANK_W | Bank address pins |
| rd_valid | output | 1 | Burst data expected on the data pins this cycle |
| busy | output | 1 | High while a new request would be refused |

## Verification
The in-design assertions check several properties on every cycle. They check the READ-to-ACTIVE spacing, the auto-precharge bit, the bank match between ACTIVE and READ, and quiet NOP cycles. They also check that no ACTIVE arrives before the full gap and that data-valid rises exactly CL cycles after a READ. The column-to-pin mapping for each width is shown only by the bench's scenarios. So are the exact cycle of a held request's second ACTIVE, the refusal of a request while busy, and the effect of a second parameter set. In those scenarios a behavioural age-based model is compared with the pins on every clock.

// File: rtl/sdram_rdap_pkg.sv
package sdram_rdap_pkg;

  // Command pin order: {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_OPEN    = 2'd1,
    ST_CLOSING = 2'd2
  } st_e;

  localparam logic [1:0] WID_X4 = 2'd0;
  localparam logic [1:0] WID_X8 = 2'd1;

  // Address pin that requests auto precharge on a READ
  localparam int AP_BIT = 10;

endpackage

// File: rtl/sdram_rdap_timer.sv
module sdram_rdap_timer #(
  parameter int W    = 4,
  parameter int LOAD = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic en,
  output logic done
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_ce;

  assign cnt_ce = load | en;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                 cnt_d = W'(LOAD);
    else if (cnt_q != '0)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // Once expired, a timer stays expired until reloaded (R8 floor at zero)
  p_timer_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done);

  // A stalled timer holds its value (R8: tRP waits behind tRAS)
  p_timer_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !en) |=> $stable(cnt_q));

endmodule

// File: rtl/sdram_rdap_colmap.sv
module sdram_rdap_colmap
  import sdram_rdap_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 12
) (
  input  logic [COL_W-1:0]  col,
  input  logic [1:0]        width,
  output logic [ADDR_W-1:0] addr
);

  logic keep_hi1, keep_hi2;

  assign keep_hi1 = (width == WID_X4) || (width == WID_X8);
  assign keep_hi2 = (width == WID_X4);

  for (genvar g = 0; g < ADDR_W; g++) begin : g_pin
    if (g < AP_BIT) begin : g_low
      assign addr[g] = col[g];
    end else if (g == AP_BIT) begin : g_ap
      assign addr[g] = 1'b1;
    end else if (g == AP_BIT + 1) begin : g_hi1
      assign addr[g] = col[AP_BIT] & keep_hi1;
    end else if (g == AP_BIT + 2) begin : g_hi2
      assign addr[g] = col[AP_BIT + 1] & keep_hi2;
    end else begin : g_zero
      assign addr[g] = 1'b0;
    end
  end

endmodule

// File: rtl/sdram_rdap_rdv.sv
module sdram_rdap_rdv #(
  parameter int CL        = 2,
  parameter int BURST_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_issue,
  output logic rd_valid
);

  localparam int L = CL + BURST_CYC;

  logic [L-1:0] sh_q, sh_d;

  assign sh_d = {sh_q[L-2:0], rd_issue};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // sh_q[k] set: READ was on the pins k cycles ago
  assign rd_valid = |sh_q[L-1:CL];

endmodule

// File: rtl/sdram_rdap_seq.sv
module sdram_rdap_seq
  import sdram_rdap_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 12,
  parameter int BANK_W = 2,
  parameter int T_RCD  = 3,
  parameter int T_RAP  = 3,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 4,
  parameter int T_RC   = 9,
  parameter int CL     = 2,
  parameter int BL     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [1:0]        cfg_width,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BANK_W-1:0] cmd_ba,
  output logic              rd_valid,
  output logic              busy
);

  localparam int TRD       = (T_RCD > T_RAP) ? T_RCD : T_RAP;
  localparam int CHAIN     = T_RAS + T_RP;
  localparam int GAP       = (T_RC > CHAIN) ? T_RC : CHAIN;
  localparam int MAXT      = GAP + 1;
  localparam int TW        = $clog2(MAXT + 1);
  localparam int BURST_CYC = BL / 2;
  localparam int AGE_W     = $clog2(GAP + 2) + 1;

  st_e               st_q, st_d;
  cmd_e              cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BANK_W-1:0] ba_q, ba_d;
  logic [ADDR_W-1:0] col_pins, col_pins_q;
  logic [BANK_W-1:0] bank_q;

  logic rcd_done, rap_done, ras_done, rp_done, rc_done;
  logic ready, accept, rd_fire;

  // ---------------- timers ----------------
  sdram_rdap_timer #(.W(TW), .LOAD(T_RCD - 1)) u_t_rcd (
    .clk(clk), .rst_n(rst_n), .load(accept), .en(1'b1), .done(rcd_done));

  sdram_rdap_timer #(.W(TW), .LOAD(T_RAP - 1)) u_t_rap (
    .clk(clk), .rst_n(rst_n), .load(accept), .en(1'b1), .done(rap_done));

  sdram_rdap_timer #(.W(TW), .LOAD(T_RAS - 1)) u_t_ras (
    .clk(clk), .rst_n(rst_n), .load(accept), .en(1'b1), .done(ras_done));

  // tRP counts only once tRAS has expired
  sdram_rdap_timer #(.W(TW), .LOAD(T_RP)) u_t_rp (
    .clk(clk), .rst_n(rst_n), .load(accept), .en(ras_done), .done(rp_done));

  sdram_rdap_timer #(.W(TW), .LOAD(T_RC - 1)) u_t_rc (
    .clk(clk), .rst_n(rst_n), .load(accept), .en(1'b1), .done(rc_done));

  // ---------------- column mapping ----------------
  sdram_rdap_colmap #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_colmap (
    .col(req_col), .width(cfg_width), .addr(col_pins));

  // ---------------- control ----------------
  assign ready   = (st_q != ST_OPEN) && rc_done && rp_done;
  assign accept  = req_valid && ready;
  assign rd_fire = (st_q == ST_OPEN) && rcd_done && rap_done;
  assign busy    = !ready;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (accept) st_d = ST_OPEN;
      ST_OPEN:    if (rd_fire) st_d = ST_CLOSING;
      ST_CLOSING: if (accept) st_d = ST_OPEN;
                  else if (ready) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    ba_d   = '0;
    if (accept) begin
      cmd_d  = CMD_ACT;
      addr_d = req_row;
      ba_d   = req_bank;
    end else if (rd_fire) begin
      cmd_d  = CMD_RD;
      addr_d = col_pins_q;
      ba_d   = bank_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      ba_q   <= '0;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      ba_q   <= ba_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_pins_q <= '0;
      bank_q     <= '0;
    end else if (accept) begin
      col_pins_q <= col_pins;
      bank_q     <= req_bank;
    end
  end

  // ---------------- read data window ----------------
  sdram_rdap_rdv #(.CL(CL), .BURST_CYC(BURST_CYC)) u_rdv (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_fire), .rd_valid(rd_valid));

  assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd_q;
  assign cmd_addr = addr_q;
  assign cmd_ba   = ba_q;

  // ---------------- assertion support ----------------
  logic [AGE_W-1:0]  act_age_q;
  logic              seen_act_q;
  logic [BANK_W-1:0] act_ba_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_age_q  <= '0;
      seen_act_q <= 1'b0;
      act_ba_q   <= '0;
    end else if (cmd_d == CMD_ACT) begin
      act_age_q  <= '0;
      seen_act_q <= 1'b1;
      act_ba_q   <= ba_d;
    end else if (act_age_q != {AGE_W{1'b1}}) begin
      act_age_q  <= act_age_q + 1'b1;
    end
  end

  p_rd_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD) |-> (seen_act_q && act_age_q == AGE_W'(TRD)));

  p_rd_autopre_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD) |-> cmd_addr[AP_BIT]);

  p_rd_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD) |-> (cmd_ba == act_ba_q));

  p_nop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_NOP) |-> (cmd_addr == '0 && cmd_ba == '0));

  p_legal_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_NOP) || (cmd_q == CMD_ACT) || (cmd_q == CMD_RD));

  p_rdv_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(cmd_q == CMD_RD, CL));

  p_act_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACT && $past(seen_act_q)) |-> ($past(act_age_q) >= AGE_W'(GAP - 1)));

  p_act_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACT) |-> busy);

endmodule

// File: tb/sdram_rdap_seq_tb.sv
`timescale 1ns/1ps

module sdram_rdap_ref #(
  parameter int TRD = 3,
  parameter int GAP = 10,
  parameter int CL  = 2,
  parameter int BC  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [12:0] req_row,
  input  logic [11:0] req_col,
  input  logic [1:0]  req_bank,
  input  logic [1:0]  cfg_width,
  output logic [3:0]  exp_cmd,
  output logic [12:0] exp_addr,
  output logic [1:0]  exp_ba,
  output logic        exp_rdv,
  output logic        exp_busy
);
  int          age;
  bit          open_row;
  logic [12:0] row_s, colp_s;
  logic [1:0]  bank_s;

  function automatic logic [12:0] pins_of(input logic [11:0] c, input logic [1:0] w);
    logic [12:0] a;
    a = '0;
    a[9:0] = c[9:0];
    a[10] = 1'b1;
    if (w == 2'd0) begin a[11] = c[10]; a[12] = c[11]; end
    else if (w == 2'd1) a[11] = c[10];
    return a;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_row <= 1'b0; age <= 0; row_s <= '0; colp_s <= '0; bank_s <= '0;
    end else if (req_valid && !(open_row && age < GAP - 1)) begin
      open_row <= 1'b1; age <= 0;
      row_s <= req_row; colp_s <= pins_of(req_col, cfg_width); bank_s <= req_bank;
    end else if (open_row && age < 100000) begin
      age <= age + 1;
    end
  end

  always_comb begin
    exp_cmd = 4'b0111; exp_addr = '0; exp_ba = '0;
    if (open_row && age == 0) begin
      exp_cmd = 4'b0011; exp_addr = row_s; exp_ba = bank_s;
    end else if (open_row && age == TRD) begin
      exp_cmd = 4'b0101; exp_addr = colp_s; exp_ba = bank_s;
    end
    exp_rdv  = open_row && age >= TRD + CL && age < TRD + CL + BC;
    exp_busy = open_row && age < GAP - 1;
  end
endmodule

module sdram_rdap_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [12:0] req_row = '0;
  logic [11:0] req_col = '0;
  logic [1:0]  req_bank = '0, cfg_width = '0;

  logic cs_a, ras_a, cas_a, we_a, rdv_a, busy_a;
  logic [12:0] addr_a; logic [1:0] ba_a;
  logic cs_b, ras_b, cas_b, we_b, rdv_b, busy_b;
  logic [12:0] addr_b; logic [1:0] ba_b;
  logic [3:0] ecmd_a, ecmd_b; logic [12:0] eaddr_a, eaddr_b;
  logic [1:0] eba_a, eba_b; logic erdv_a, erdv_b, ebusy_a, ebusy_b;

  int vectors = 0, fails = 0, cycles = 0;
  bit done_flag = 1'b0;
  string phase = "R2";

  always #2.5 clk = ~clk;

  sdram_rdap_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
    .req_col(req_col), .req_bank(req_bank), .cfg_width(cfg_width),
    .cmd_cs_n(cs_a), .cmd_ras_n(ras_a), .cmd_cas_n(cas_a), .cmd_we_n(we_a),
    .cmd_addr(addr_a), .cmd_ba(ba_a), .rd_valid(rdv_a), .busy(busy_a));

  // R10: tRAP longer than tRCD, tRC longer than tRAS+tRP
  sdram_rdap_seq #(.T_RCD(3), .T_RAP(4), .T_RAS(6), .T_RP(4), .T_RC(14)) u_dut_alt (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
    .req_col(req_col), .req_bank(req_bank), .cfg_width(cfg_width),
    .cmd_cs_n(cs_b), .cmd_ras_n(ras_b), .cmd_cas_n(cas_b), .cmd_we_n(we_b),
    .cmd_addr(addr_b), .cmd_ba(ba_b), .rd_valid(rdv_b), .busy(busy_b));

  sdram_rdap_ref #(.TRD(3), .GAP(10), .CL(2), .BC(2)) u_ref_a (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
    .req_col(req_col), .req_bank(req_bank), .cfg_width(cfg_width),
    .exp_cmd(ecmd_a), .exp_addr(eaddr_a), .exp_ba(eba_a), .exp_rdv(erdv_a), .exp_busy(ebusy_a));

  sdram_rdap_ref #(.TRD(4), .GAP(14), .CL(2), .BC(2)) u_ref_b (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
    .req_col(req_col), .req_bank(req_bank), .cfg_width(cfg_width),
    .exp_cmd(ecmd_b), .exp_addr(eaddr_b), .exp_ba(eba_b), .exp_rdv(erdv_b), .exp_busy(ebusy_b));

  function automatic string cmd_tag(input logic [3:0] c);
    if (c == 4'b0011) return "R2";
    if (c == 4'b0101) return "R3";
    return "R6";
  endfunction

  task automatic cmp(input string who, input logic [3:0] cmd, input logic [12:0] addr,
                     input logic [1:0] ba, input logic rdv, input logic bsy,
                     input logic [3:0] ecmd, input logic [12:0] eaddr,
                     input logic [1:0] eba, input logic erdv, input logic ebsy);
    vectors++;
    if (cmd !== ecmd) begin fails++;
      $display("FAIL %s %s [%s] cmd got %b exp %b t=%0t", cmd_tag(ecmd), who, phase, cmd, ecmd, $time); end
    vectors++;
    if (addr !== eaddr) begin fails++;
      $display("FAIL %s %s [%s] addr got %h exp %h t=%0t", (ecmd == 4'b0101) ? "R4" : cmd_tag(ecmd), who, phase, addr, eaddr, $time); end
    vectors++;
    if (ba !== eba) begin fails++;
      $display("FAIL %s %s [%s] ba got %0d exp %0d t=%0t", (ecmd == 4'b0101) ? "R5" : cmd_tag(ecmd), who, phase, ba, eba, $time); end
    vectors++;
    if (rdv !== erdv) begin fails++;
      $display("FAIL R7 %s [%s] rd_valid got %b exp %b t=%0t", who, phase, rdv, erdv, $time); end
    vectors++;
    if (bsy !== ebsy) begin fails++;
      $display("FAIL R8 %s [%s] busy got %b exp %b t=%0t", who, phase, bsy, ebsy, $time); end
  endtask

  always @(negedge clk) begin
    if (!done_flag) begin
      cmp("base", {cs_a, ras_a, cas_a, we_a}, addr_a, ba_a, rdv_a, busy_a,
          ecmd_a, eaddr_a, eba_a, erdv_a, ebusy_a);
      cmp("R10 alt", {cs_b, ras_b, cas_b, we_b}, addr_b, ba_b, rdv_b, busy_b,
          ecmd_b, eaddr_b, eba_b, erdv_b, ebusy_b);
    end
  end

  task automatic finish_run();
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done_flag) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic wait_idle();
    while (busy_a || busy_b) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic request(input logic [12:0] row, input logic [11:0] col,
                         input logic [1:0] bank, input logic [1:0] w);
    req_valid = 1'b1; req_row = row; req_col = col; req_bank = bank; cfg_width = w;
    @(negedge clk);
    req_valid = 1'b0; req_row = '0; req_col = '0; req_bank = '0; cfg_width = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the pins
    vectors++;
    if ({cs_a, ras_a, cas_a, we_a} !== 4'b0111 || addr_a !== '0 || ba_a !== '0 ||
        rdv_a !== 1'b0 || busy_a !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset pins got cmd=%b addr=%h ba=%0d rdv=%b busy=%b exp 0111/0/0/0/0",
               {cs_a, ras_a, cas_a, we_a}, addr_a, ba_a, rdv_a, busy_a);
    end

    phase = "R4 x4";  request(13'h1234, 12'hFFF, 2'd1, 2'd0); wait_idle();
    phase = "R4 x8";  request(13'h0ABC, 12'hFFF, 2'd2, 2'd1); wait_idle();
    phase = "R4 x16"; request(13'h1FFF, 12'hFFF, 2'd3, 2'd2); wait_idle();
    phase = "R4 code3"; request(13'h0001, 12'hC55, 2'd0, 2'd3); wait_idle();
    phase = "R4 mixed"; request(13'h0F0F, 12'h9AA, 2'd2, 2'd0); wait_idle();

    // R8: held request, next ACTIVE exactly at the gap
    phase = "R8 held";
    req_valid = 1'b1; req_row = 13'h0777; req_col = 12'h3C3; req_bank = 2'd1; cfg_width = 2'd1;
    repeat (45) @(negedge clk);
    req_valid = 1'b0; req_row = '0; req_col = '0; req_bank = '0; cfg_width = '0;
    wait_idle();

    // R9: pulse while busy is ignored
    phase = "R9 ignored";
    request(13'h0100, 12'h011, 2'd2, 2'd0);
    repeat (3) @(negedge clk);
    request(13'h1EEE, 12'hEEE, 2'd3, 2'd0);
    request(13'h1DDD, 12'hDDD, 2'd0, 2'd1);
    wait_idle();

    phase = "R3 final"; request(13'h0042, 12'h024, 2'd3, 2'd1); wait_idle();
    finish_run();
  end
endmodule